// File: doc/BRIEF.md
# Interlaced 8-bit Digital Video Framer

This block turns a stream of 4:2:2 YCbCr pixels into a byte-wide interlaced video stream. Every output line has 720 active pixels, sent as 1440 bytes in which each pixel contributes its chroma byte and then its luma byte. Chroma alternates between Cb and Cr from one pixel to the next. Each line opens with a programmable run of horizontal blanking bytes. A frame holds a programmable number of lines. These lines are split between two independently bounded fields, and two separate vertical blanking windows are laid over them.

The upstream source supplies one pixel per handshake. When the programmed input width is less than 720, the framer pads the right end of each active line with a programmable fill colour. The fill count is capped at 255 pixels, so no input narrower than 465 pixels is accepted. The byte stream runs on a fixed timebase and never waits for the source. A pixel the source fails to deliver in time is replaced by fill.

Top module: `vfr_top`

## Requirements
- R1: While reset is held, dataOut is 0x80, hBlankOut and vBlankOut are 1, fieldOut, frameStartOut and pixReady are 0, and lineNumOut is 0. The first clock edge after reset emits byte position 0 of line 1.
- R2: Every line is hBlankCnt + 1440 bytes long, one byte per clock. hBlankOut is 1 for the first hBlankCnt bytes of every line and 0 for the remaining 1440.
- R3: Lines are numbered from 1 to vLines and wrap back to 1. lineNumOut gives the number of the line the current byte belongs to. frameStartOut is 1 only on byte 0 of line 1.
- R4: vBlankOut is 1 on every line inside either window, [vb1Start, vb1End] or [vb2Start, vb2End], bounds included. Such lines carry only blanking bytes, even when they fall inside a field range, and pixReady stays 0 on them.
- R5: fieldOut is 1 on lines inside [f2Start, f2End] and 0 elsewhere. Active video appears only on lines inside [f1Start, f1End] or [f2Start, f2End] that are outside both blanking windows.
- R6: A blanking byte at line position p (counted from 0) is 0x80 if p is even and 0x10 if p is odd.
- R7: Active byte 2n carries the chroma of pixel n, taken from pixIn[15:8], and active byte 2n+1 carries its luma, taken from pixIn[7:0]. The chroma is Cb for even n and Cr for odd n, as supplied by the source.
- R8: pixReady is 1 for exactly one clock per pixel n below the effective width on an active line: the clock just before that pixel's chroma byte appears. A pixel is taken only when pixValid and pixReady are both 1.
- R9: A pixel n at or beyond the effective width is sent as fill: its chroma byte is fillCb for even n and fillCr for odd n, and its luma byte is fillY.
- R10: The effective width is inWidth clamped to the range 465 to 720. A smaller value acts as 465 and a larger one acts as 720.
- R11: If pixValid is 0 while pixReady is 1, that pixel position is sent as fill (chroma by the parity of n, and fillY). No pixel is consumed, so the next accepted pixel goes to the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | 16 | Source pixel: chroma in [15:8], luma in [7:0] |
| pixValid | input | 1 | Source pixel available |
| pixReady | output | 1 | Framer takes a pixel at this clock edge |
| hBlankCnt | input | 10 | Horizontal blanking bytes per line |
| vLines | input | 11 | Total lines per frame |
| f1Start | input | 11 | First line of field 1 |
| f1End | input | 11 | Last line of field 1 |
| f2Start | input | 11 | First line of field 2 |
| f2End | input | 11 | Last line of field 2 |
| vb1Start | input | 11 | First line of blanking window 1 |
| vb1End | input | 11 | Last line of blanking window 1 |
| vb2Start | input | 11 | First line of blanking window 2 |
| vb2End | input | 11 | Last line of blanking window 2 |
| inWidth | input | 10 | Source pixels per line |
| fillY | input | 8 | Fill luma |
| fillCb | input | 8 | Fill blue-difference chroma |
| fillCr | input | 8 | Fill red-difference chroma |
| dataOut | output | 8 | Output byte |
| hBlankOut | output | 1 | Byte lies in horizontal blanking |
| vBlankOut | output | 1 | Line lies in a vertical blanking window |
| fieldOut | output | 1 | 0 for field 1, 1 for field 2 |
| frameStartOut | output | 1 | First byte of line 1 |
| lineNumOut | output | 11 | Line number of the current byte |

## Verification
The bench programs a line that falls inside field 1 and also inside a blanking window. A framer that let field membership win over blanking would then send pixels on that line. Widths of 300 and 1000 test the clamp: a missing lower clamp pads more than 255 pixels, and a missing upper clamp runs the source past the line end. Programmed non-default fill values reveal a swapped Cb and Cr or a luma taken from the wrong register. Periodic gaps in pixValid test starvation handling: a framer that stalled or consumed a pixel during a gap would shift every later pixel on the line.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
  // Per-byte strobes from the timing control to the byte datapath
  typedef struct packed {
    logic videoOn;    // byte lies in active video
    logic bytePhase;  // 0: chroma/even position, 1: luma/odd position
    logic chromaCr;   // active pixel index is odd
    logic wantPix;    // a source pixel is taken at this edge
    logic frameStart;
    logic field;
    logic vBlank;
    logic hBlank;
  } vfr_strobe_t;

  localparam logic [7:0] CHROMA_BLANK = 8'h80;
  localparam logic [7:0] LUMA_BLANK   = 8'h10;
endpackage

// File: rtl/vfr_ctrl.sv
module vfr_ctrl
  import vfr_pkg::*;
#(
  parameter int ACT_PIX  = 720,
  parameter int MAX_FILL = 255,
  parameter int HB_W     = 10,
  parameter int LINE_W   = 11,
  parameter int PIX_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HB_W-1:0]   hBlankCnt,
  input  logic [LINE_W-1:0] vLines,
  input  logic [LINE_W-1:0] f1Start,
  input  logic [LINE_W-1:0] f1End,
  input  logic [LINE_W-1:0] f2Start,
  input  logic [LINE_W-1:0] f2End,
  input  logic [LINE_W-1:0] vb1Start,
  input  logic [LINE_W-1:0] vb1End,
  input  logic [LINE_W-1:0] vb2Start,
  input  logic [LINE_W-1:0] vb2End,
  input  logic [PIX_W-1:0]  inWidth,
  output vfr_strobe_t       st,
  output logic [LINE_W-1:0] lineNum
);
  localparam int ACT_BYTES = 2 * ACT_PIX;
  localparam int MIN_W     = ACT_PIX - MAX_FILL;
  localparam int CNT_W     = $clog2(ACT_BYTES + (1 << HB_W));

  logic [CNT_W-1:0]  hCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [CNT_W-1:0]  lineLen;
  logic [CNT_W-1:0]  actByte;
  logic [CNT_W-2:0]  pixIdx;
  logic [PIX_W-1:0]  effWidth;
  logic              lastByte, inVb, inF1, inF2, lineActive, inHActive;

  function automatic logic inRange(input logic [LINE_W-1:0] v, lo, hi);
    return (v >= lo) && (v <= hi);
  endfunction

  assign lineLen  = CNT_W'(hBlankCnt) + CNT_W'(ACT_BYTES);
  assign lastByte = (hCnt == lineLen - CNT_W'(1));

  // Line and byte counters: free running, never stalled by the source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      lineCnt <= LINE_W'(1);
    end else if (lastByte) begin
      hCnt    <= '0;
      lineCnt <= (lineCnt >= vLines) ? LINE_W'(1) : lineCnt + LINE_W'(1);
    end else begin
      hCnt <= hCnt + CNT_W'(1);
    end
  end

  // Width clamp keeps the fill count within its limit
  always_comb begin
    if (inWidth < PIX_W'(MIN_W))        effWidth = PIX_W'(MIN_W);
    else if (inWidth > PIX_W'(ACT_PIX)) effWidth = PIX_W'(ACT_PIX);
    else                                effWidth = inWidth;
  end

  assign inVb       = inRange(lineCnt, vb1Start, vb1End) || inRange(lineCnt, vb2Start, vb2End);
  assign inF1       = inRange(lineCnt, f1Start, f1End);
  assign inF2       = inRange(lineCnt, f2Start, f2End);
  assign lineActive = (inF1 || inF2) && !inVb;
  assign inHActive  = (hCnt >= CNT_W'(hBlankCnt));
  assign actByte    = hCnt - CNT_W'(hBlankCnt);
  assign pixIdx     = actByte[CNT_W-1:1];

  always_comb begin
    st            = '0;
    st.videoOn    = lineActive && inHActive;
    st.bytePhase  = st.videoOn ? actByte[0] : hCnt[0];
    st.chromaCr   = pixIdx[0];
    st.wantPix    = st.videoOn && !actByte[0] && (pixIdx < (CNT_W-1)'(effWidth));
    st.frameStart = (lineCnt == LINE_W'(1)) && (hCnt == '0);
    st.field      = inF2;
    st.vBlank     = inVb;
    st.hBlank     = !inHActive;
  end

  assign lineNum = lineCnt;

  AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    lastByte |=> (hCnt == '0)); // R2
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (lastByte && (lineCnt >= vLines)) |=> (lineCnt == LINE_W'(1))); // R3
  AST_LINE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt != '0); // R3
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    st.frameStart |=> !st.frameStart); // R3
  AST_READY_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    st.wantPix |=> !st.wantPix); // R8
  AST_NO_PIX_IN_VBLANK: assert property (@(posedge clk) disable iff (!rstN)
    st.vBlank |-> !st.wantPix); // R4
endmodule

// File: rtl/vfr_dpath.sv
module vfr_dpath
  import vfr_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfr_strobe_t       st,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [15:0]       pixIn,
  input  logic              pixValid,
  input  logic [7:0]        fillY,
  input  logic [7:0]        fillCb,
  input  logic [7:0]        fillCr,
  output logic [7:0]        dataOut,
  output logic              hBlankOut,
  output logic              vBlankOut,
  output logic              fieldOut,
  output logic              frameStartOut,
  output logic [LINE_W-1:0] lineNumOut
);
  logic [7:0] lumaHold;
  logic       takePix;

  assign takePix = st.wantPix && pixValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut       <= CHROMA_BLANK;
      lumaHold      <= LUMA_BLANK;
      hBlankOut     <= 1'b1;
      vBlankOut     <= 1'b1;
      fieldOut      <= 1'b0;
      frameStartOut <= 1'b0;
      lineNumOut    <= '0;
    end else begin
      hBlankOut     <= st.hBlank;
      vBlankOut     <= st.vBlank;
      fieldOut      <= st.field;
      frameStartOut <= st.frameStart;
      lineNumOut    <= lineNum;
      if (!st.videoOn) begin
        dataOut <= st.bytePhase ? LUMA_BLANK : CHROMA_BLANK;
      end else if (!st.bytePhase) begin
        if (takePix) begin
          dataOut  <= pixIn[15:8];
          lumaHold <= pixIn[7:0];
        end else begin
          dataOut  <= st.chromaCr ? fillCr : fillCb;
          lumaHold <= fillY;
        end
      end else begin
        dataOut <= lumaHold;
      end
    end
  end

  AST_CHROMA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    takePix |=> (dataOut == $past(pixIn[15:8]))); // R7
  AST_LUMA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    takePix |=> ##1 (dataOut == $past(pixIn[7:0], 2))); // R7
  AST_STARVE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (st.wantPix && !pixValid) |=> ##1 (dataOut == $past(fillY, 2))); // R11
  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !st.videoOn |=> (dataOut == CHROMA_BLANK || dataOut == LUMA_BLANK)); // R6
endmodule

// File: rtl/vfr_top.sv
module vfr_top
  import vfr_pkg::*;
#(
  parameter int ACT_PIX  = 720,
  parameter int MAX_FILL = 255,
  parameter int HB_W     = 10,
  parameter int LINE_W   = 11,
  parameter int PIX_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       pixIn,
  input  logic              pixValid,
  output logic              pixReady,
  input  logic [HB_W-1:0]   hBlankCnt,
  input  logic [LINE_W-1:0] vLines,
  input  logic [LINE_W-1:0] f1Start,
  input  logic [LINE_W-1:0] f1End,
  input  logic [LINE_W-1:0] f2Start,
  input  logic [LINE_W-1:0] f2End,
  input  logic [LINE_W-1:0] vb1Start,
  input  logic [LINE_W-1:0] vb1End,
  input  logic [LINE_W-1:0] vb2Start,
  input  logic [LINE_W-1:0] vb2End,
  input  logic [PIX_W-1:0]  inWidth,
  input  logic [7:0]        fillY,
  input  logic [7:0]        fillCb,
  input  logic [7:0]        fillCr,
  output logic [7:0]        dataOut,
  output logic              hBlankOut,
  output logic              vBlankOut,
  output logic              fieldOut,
  output logic              frameStartOut,
  output logic [LINE_W-1:0] lineNumOut
);
  vfr_strobe_t       st;
  logic [LINE_W-1:0] lineNum;

  vfr_ctrl #(
    .ACT_PIX(ACT_PIX), .MAX_FILL(MAX_FILL), .HB_W(HB_W),
    .LINE_W(LINE_W), .PIX_W(PIX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hBlankCnt(hBlankCnt), .vLines(vLines),
    .f1Start(f1Start), .f1End(f1End), .f2Start(f2Start), .f2End(f2End),
    .vb1Start(vb1Start), .vb1End(vb1End), .vb2Start(vb2Start), .vb2End(vb2End),
    .inWidth(inWidth), .st(st), .lineNum(lineNum)
  );

  vfr_dpath #(.LINE_W(LINE_W)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .lineNum(lineNum),
    .pixIn(pixIn), .pixValid(pixValid),
    .fillY(fillY), .fillCb(fillCb), .fillCr(fillCr),
    .dataOut(dataOut), .hBlankOut(hBlankOut), .vBlankOut(vBlankOut),
    .fieldOut(fieldOut), .frameStartOut(frameStartOut), .lineNumOut(lineNumOut)
  );

  assign pixReady = st.wantPix;
endmodule

// File: tb/sim_vfr_top.sv
`timescale 1ns/1ps
module sim_vfr_top;
  localparam int HB = 8;
  localparam int VL = 8;
  localparam int LINE_LEN = HB + 1440;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [15:0] pixIn = '0;
  logic        pixValid = 1'b0;
  logic        pixReady;
  logic [9:0]  inWidth = 10'd720;
  logic [7:0]  fillY = 8'd16, fillCb = 8'd128, fillCr = 8'd128;
  logic [7:0]  dataOut;
  logic        hBlankOut, vBlankOut, fieldOut, frameStartOut;
  logic [10:0] lineNumOut;

  // Lines: 1 and 5 blanked; field 1 = 2..5 (5 overlaps blanking), field 2 = 6..8
  vfr_top u0 (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .pixValid(pixValid), .pixReady(pixReady),
    .hBlankCnt(10'(HB)), .vLines(11'(VL)),
    .f1Start(11'd2), .f1End(11'd5), .f2Start(11'd6), .f2End(11'd8),
    .vb1Start(11'd1), .vb1End(11'd1), .vb2Start(11'd5), .vb2End(11'd5),
    .inWidth(inWidth), .fillY(fillY), .fillCb(fillCb), .fillCr(fillCr),
    .dataOut(dataOut), .hBlankOut(hBlankOut), .vBlankOut(vBlankOut),
    .fieldOut(fieldOut), .frameStartOut(frameStartOut), .lineNumOut(lineNumOut)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  int errN[12];
  int firstAct[12], firstExp[12];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic note(int t, int act, int exp);
    if (act != exp) begin
      if (errN[t] == 0) begin firstAct[t] = act; firstExp[t] = exp; end
      errN[t]++;
    end
  endtask

  task automatic report(string scen, string tag, int t);
    check(errN[t] == 0, tag, $sformatf("%s first mismatch (%0d bad bytes)", scen, errN[t]),
          firstAct[t], firstExp[t]);
  endtask

  function automatic int effW(int w);
    return (w < 465) ? 465 : (w > 720) ? 720 : w;
  endfunction
  function automatic bit isVb(int ln);   return (ln == 1) || (ln == 5); endfunction
  function automatic bit isF2(int ln);   return (ln >= 6) && (ln <= 8); endfunction
  function automatic bit isAct(int ln);  return (ln >= 2) && (ln <= 8) && !isVb(ln); endfunction
  function automatic logic [15:0] pat(int k);
    return {8'(k * 3 + 1), 8'(k * 5 + 7)};
  endfunction
  function automatic bit expReady(int k, int w);
    int pos = k % LINE_LEN;
    int ln = (k / LINE_LEN) % VL + 1;
    int a = pos - HB;
    return isAct(ln) && (pos >= HB) && (a % 2 == 0) && (a / 2 < effW(w));
  endfunction

  task automatic doReset();
    rstN = 1'b0; pixValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Runs ncyc bytes from reset release; dataTag overrides the tag of active bytes
  task automatic runScenario(string scen, int w, int fy, int fcb, int fcr,
                             bit starve, int ncyc, int dataTag);
    int srcK = 0, reqCnt = 0;
    bit pendOk = 0, curOk = 0;
    logic [15:0] pendPix = '0, curPix = '0;
    foreach (errN[i]) errN[i] = 0;
    inWidth = 10'(w); fillY = 8'(fy); fillCb = 8'(fcb); fillCr = 8'(fcr);
    doReset();
    rstN = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      int pos, ln, a, n, expD, tag;
      bit vid;
      @(negedge clk);
      pos = k % LINE_LEN;
      ln  = (k / LINE_LEN) % VL + 1;
      vid = isAct(ln) && (pos >= HB);
      if (!vid) begin
        expD = (pos % 2 == 1) ? 8'h10 : 8'h80;
        tag  = isVb(ln) ? 4 : 6;
      end else begin
        a = pos - HB; n = a / 2;
        if (n >= effW(w)) begin
          expD = (a % 2 == 1) ? fy : ((n % 2 == 1) ? fcr : fcb);
          tag  = 9;
        end else begin
          if (a % 2 == 0) begin curOk = pendOk; curPix = pendPix; end
          if (curOk) expD = (a % 2 == 1) ? int'(curPix[7:0]) : int'(curPix[15:8]);
          else       expD = (a % 2 == 1) ? fy : ((n % 2 == 1) ? fcr : fcb);
          tag = curOk ? 7 : 11;
        end
        if (dataTag != 0) tag = dataTag;
      end
      note(tag, int'(dataOut), expD);
      note(2, int'(hBlankOut), int'(pos < HB));
      note(3, int'(lineNumOut), ln);
      note(3, int'(frameStartOut), int'(ln == 1 && pos == 0));
      note(4, int'(vBlankOut), int'(isVb(ln)));
      note(5, int'(fieldOut), int'(isF2(ln)));
      note(8, int'(pixReady), int'(expReady(k + 1, w)));
      // drive the source for the next edge
      pixIn = pat(srcK);
      if (expReady(k + 1, w)) begin
        pendOk = !(starve && (reqCnt % 7 == 3));
        pendPix = pat(srcK);
        pixValid = pendOk;
        if (pendOk) srcK++;
        reqCnt++;
      end else begin
        pixValid = 1'b1; // offered without ready: must not be consumed (R8)
      end
    end
  endtask

  task automatic testReset();
    doReset();
    check(dataOut == 8'h80, "R1", "reset dataOut", int'(dataOut), 8'h80);
    check(hBlankOut && vBlankOut, "R1", "reset blank flags", int'({hBlankOut, vBlankOut}), 3);
    check(!fieldOut && !frameStartOut, "R1", "reset field/frameStart", int'({fieldOut, frameStartOut}), 0);
    check(lineNumOut == 0, "R1", "reset lineNum", int'(lineNumOut), 0);
    check(!pixReady, "R1", "reset ready", int'(pixReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(frameStartOut && lineNumOut == 1, "R1", "first byte is line 1 start",
          int'({frameStartOut, lineNumOut}), int'({1'b1, 11'd1}));
  endtask

  task automatic testFullWidth();
    runScenario("full", 720, 16, 128, 128, 0, VL * LINE_LEN + 40, 0);
    report("full", "R2", 2); report("full", "R3", 3); report("full", "R4", 4);
    report("full", "R5", 5); report("full", "R6", 6); report("full", "R7", 7);
    report("full", "R8", 8);
  endtask

  task automatic testFill();
    runScenario("fill600", 600, 8'h21, 8'h95, 8'h6a, 0, 4 * LINE_LEN, 0);
    report("fill600", "R9", 9); report("fill600", "R7", 7); report("fill600", "R8", 8);
    runScenario("fillDefault", 465, 16, 128, 128, 0, 3 * LINE_LEN, 0);
    report("fillDefault", "R9", 9);
  endtask

  task automatic testClamp();
    runScenario("clampLow", 300, 8'h33, 8'h44, 8'h55, 0, 3 * LINE_LEN, 10);
    report("clampLow", "R10", 10); report("clampLow", "R8", 8);
    runScenario("clampHigh", 1000, 8'h33, 8'h44, 8'h55, 0, 3 * LINE_LEN, 10);
    report("clampHigh", "R10", 10); report("clampHigh", "R8", 8);
  endtask

  task automatic testStarve();
    runScenario("starve", 700, 8'h2b, 8'h9c, 8'h5d, 1, 4 * LINE_LEN, 0);
    report("starve", "R11", 11); report("starve", "R7", 7); report("starve", "R9", 9);
  endtask

  initial begin
    testReset();
    testFullWidth();
    testFill();
    testClamp();
    testStarve();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule